// File: doc/BRIEF.md
# Multi-Device SPI Chip-Select Controller

This block generates the chip-select lines of an SPI master that serves several devices on one bus. A small target field picks one device; every other line is parked at the inactive level. A single polarity input defines both the active level of the chosen line and the rest level of all the others. When the polarity input is high, the lines are active-low and rest high. When it is low, the lines are active-high and rest low.

In automatic mode the chosen line follows the busy signal of the transfer engine. It is asserted one clock after busy is first seen high. It is held for a parameterised tail of `TAIL_CYC` clock cycles after busy is last seen high, where `TAIL_CYC` is set to one serial clock period. The engine is expected to raise busy at least one serial period before its first SCLK edge. In manual mode, software drives the raw level of the chosen line directly, and busy is ignored.

The target field is captured only while no burst is engaged. A change written in the middle of a burst therefore waits until the line has been released. Serial shifting and clock generation live elsewhere.

Top module: `cs_select_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all chip-select outputs are 1.
- R2: Every line other than the captured target rests at the inactive level: 1 when `low_active` is 1 and 0 when `low_active` is 0. At most one line differs from that level.
- R3: In automatic mode (`man_mode`=0), the target line takes the active level (the complement of the inactive level) after the second clock edge at which `xfer_busy` has been sampled high. It is not active after the first such edge.
- R4: In automatic mode, the target line stays active for `TAIL_CYC` clock cycles after the last edge at which `xfer_busy` was sampled high. It returns to the inactive level at the edge after that.
- R5: `tgt_sel` is captured only at edges where no burst is engaged. A change made while a line is engaged has no effect on any output until that line is released. The new target then takes effect for the next burst.
- R6: In manual mode (`man_mode`=1), the target line is driven with the raw value of `man_level` one edge after it is applied, whatever the value of `xfer_busy` or `low_active`.
- R7: A change of `low_active` reaches every non-target line one edge after it is applied.
- R8: The target value i (0 to 3) controls output bit `cs_pins[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_sel | input | 2 | Target device number |
| man_mode | input | 1 | 1 = manual line control, 0 = automatic |
| man_level | input | 1 | Raw level for the target line in manual mode |
| low_active | input | 1 | 1 = lines are active-low and rest high |
| xfer_busy | input | 1 | Burst in progress, from the transfer engine |
| cs_pins | output | 4 | Chip-select outputs, one per device |

## Verification
The bench builds the block with four lines and `TAIL_CYC` = 3. With this short tail, the exact release edge of R4 and the deferred capture of a mid-burst target change (R5) can be counted cycle by cycle. Both polarities are exercised in automatic and manual mode, and every target value is walked so that each output bit is seen going active on its own.

// File: rtl/cs_select_pkg.sv
package cs_select_pkg;

  // Level of one line from its role and the control inputs.
  function automatic logic cs_line_level(
    input logic is_tgt,
    input logic manual,
    input logic raw_level,
    input logic engaged,
    input logic low_act
  );
    if (!is_tgt)
      return low_act;
    if (manual)
      return raw_level;
    return engaged ? ~low_act : low_act;
  endfunction

  // Tail counter reload value, sized to the counter.
  function automatic int tail_load(input int tail_cyc);
    return (tail_cyc < 1) ? 1 : tail_cyc;
  endfunction

endpackage

// File: rtl/cs_target_latch.sv
module cs_target_latch #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             engaged,
  input  logic [SEL_W-1:0] tgt_in,
  output logic [SEL_W-1:0] tgt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tgt_q <= '0;
    else if (!engaged)
      tgt_q <= tgt_in;
  end
endmodule

// File: rtl/cs_hold_timer.sv
module cs_hold_timer
  import cs_select_pkg::*;
#(
  parameter int TAIL_CYC = 4,
  localparam int CNT_W = $clog2(tail_load(TAIL_CYC) + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic engaged
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(tail_load(TAIL_CYC));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (busy)
      cnt_q <= LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign engaged = (cnt_q != '0);
endmodule

// File: rtl/cs_line_drive.sv
module cs_line_drive
  import cs_select_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  tgt_q,
  input  logic              manual,
  input  logic              raw_level,
  input  logic              engaged,
  input  logic              low_act,
  output logic [NUM_CS-1:0] lines
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic is_tgt;
    assign is_tgt = (int'(tgt_q) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lines[i] <= 1'b1;
      else
        lines[i] <= cs_line_level(is_tgt, manual, raw_level, engaged, low_act);
    end
  end
endmodule

// File: rtl/cs_select_ctrl.sv
module cs_select_ctrl #(
  parameter int NUM_CS   = 4,
  parameter int TAIL_CYC = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  tgt_sel,
  input  logic              man_mode,
  input  logic              man_level,
  input  logic              low_active,
  input  logic              xfer_busy,
  output logic [NUM_CS-1:0] cs_pins
);
  logic             engaged;
  logic [SEL_W-1:0] tgt_q;

  cs_hold_timer #(.TAIL_CYC(TAIL_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (xfer_busy),
    .engaged (engaged)
  );

  cs_target_latch #(.SEL_W(SEL_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .engaged (engaged),
    .tgt_in  (tgt_sel),
    .tgt_q   (tgt_q)
  );

  cs_line_drive #(.NUM_CS(NUM_CS)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_q     (tgt_q),
    .manual    (man_mode),
    .raw_level (man_level),
    .engaged   (engaged),
    .low_act   (low_active),
    .lines     (cs_pins)
  );
endmodule

// File: rtl/cs_select_chk.sv
module cs_select_chk #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              man_mode,
  input logic              man_level,
  input logic              low_active,
  input logic              xfer_busy,
  input logic              engaged,
  input logic [SEL_W-1:0]  tgt_q,
  input logic [NUM_CS-1:0] cs_pins
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  reset_level_chk: assert property (@(posedge clk)
    !rst_n |=> (cs_pins == '1));

  // R2
  single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones(cs_pins ^ {NUM_CS{$past(low_active)}}) <= 1));

  // R3
  busy_engages_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(xfer_busy)) |-> engaged);

  // R5
  target_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(engaged)) |-> $stable(tgt_q));

  // R6
  manual_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(man_mode)) |-> (cs_pins[$past(tgt_q)] == $past(man_level)));
endmodule

bind cs_select_ctrl cs_select_chk #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .man_mode   (man_mode),
  .man_level  (man_level),
  .low_active (low_active),
  .xfer_busy  (xfer_busy),
  .engaged    (engaged),
  .tgt_q      (tgt_q),
  .cs_pins    (cs_pins)
);

// File: tb/sim_cs_select_ctrl.sv
module sim_cs_select_ctrl;
  localparam int N = 4;
  localparam int T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tgt_sel = 2'd0;
  logic man_mode = 1'b0, man_level = 1'b0, low_active = 1'b1, xfer_busy = 1'b0;
  logic [N-1:0] cs_pins;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cs_select_ctrl #(.NUM_CS(N), .TAIL_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .man_mode(man_mode),
    .man_level(man_level), .low_active(low_active), .xfer_busy(xfer_busy),
    .cs_pins(cs_pins)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected pattern: all inactive except optional target at active level.
  function automatic logic [N-1:0] pat(input logic low, input int tgt, input logic on);
    logic [N-1:0] v = {N{low}};
    if (on) v[tgt] = ~low;
    return v;
  endfunction

  task automatic t_reset();
    step(1);
    chk("R1 during reset", cs_pins, '1);
    rst_n = 1'b1;
    step(1);
    chk("R1 first clock after reset", cs_pins, '1);
  endtask

  // Burst of b busy cycles on target tg with polarity low.
  task automatic t_burst(input logic low, input int tg, input int b, input string tag);
    low_active = low; tgt_sel = 2'(tg); man_mode = 1'b0;
    step(2);
    chk({tag, " R2 idle"}, cs_pins, pat(low, tg, 1'b0));
    xfer_busy = 1'b1;
    step(1);
    chk({tag, " R3 not yet active"}, cs_pins, pat(low, tg, 1'b0));
    step(1);
    chk({tag, " R3 active"}, cs_pins, pat(low, tg, 1'b1));
    step(b - 2);
    xfer_busy = 1'b0;
    step(T);
    chk({tag, " R4 held through tail"}, cs_pins, pat(low, tg, 1'b1));
    step(1);
    chk({tag, " R4 released"}, cs_pins, pat(low, tg, 1'b0));
  endtask

  task automatic t_midburst_change();
    low_active = 1'b1; tgt_sel = 2'd1;
    step(2);
    xfer_busy = 1'b1;
    step(2);
    tgt_sel = 2'd3;
    step(2);
    chk("R5 change mid-burst ignored", cs_pins, pat(1'b1, 1, 1'b1));
    xfer_busy = 1'b0;
    step(T);
    chk("R5 old target kept in tail", cs_pins, pat(1'b1, 1, 1'b1));
    step(2);
    xfer_busy = 1'b1;
    step(2);
    chk("R5 new target on next burst", cs_pins, pat(1'b1, 3, 1'b1));
    xfer_busy = 1'b0;
    step(T + 2);
  endtask

  task automatic t_manual();
    man_mode = 1'b1; low_active = 1'b1; tgt_sel = 2'd2; man_level = 1'b1;
    step(2);
    man_level = 1'b0;
    step(1);
    chk("R6 manual low, low-active", cs_pins, 4'b1011);
    man_level = 1'b1;
    step(1);
    chk("R6 manual high, low-active", cs_pins, 4'b1111);
    low_active = 1'b0;
    step(1);
    chk("R6 manual high, active-high", cs_pins, 4'b0100);
    xfer_busy = 1'b1; man_level = 1'b0;
    step(2);
    chk("R6 manual ignores busy", cs_pins, 4'b0000);
    xfer_busy = 1'b0; man_mode = 1'b0;
    step(T + 2);
  endtask

  task automatic t_polarity();
    tgt_sel = 2'd0; low_active = 1'b1;
    step(2);
    chk("R7 idle high", cs_pins, 4'b1111);
    low_active = 1'b0;
    step(1);
    chk("R7 idle low after flip", cs_pins, 4'b0000);
    low_active = 1'b1;
    step(1);
    chk("R7 idle high after flip back", cs_pins, 4'b1111);
  endtask

  task automatic t_encoding();
    for (int i = 0; i < N; i++) begin
      tgt_sel = 2'(i); low_active = 1'b1;
      step(2);
      xfer_busy = 1'b1;
      step(2);
      chk($sformatf("R8 target %0d", i), cs_pins, pat(1'b1, i, 1'b1));
      xfer_busy = 1'b0;
      step(T + 2);
    end
  endtask

  initial begin
    t_reset();
    t_burst(1'b1, 2, 5, "low-active");
    t_burst(1'b0, 0, 4, "active-high");
    t_burst(1'b1, 3, 2, "short");
    t_midburst_change();
    t_manual();
    t_polarity();
    t_encoding();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule